// File: doc/BRIEF.md
# DMA Start Vector Dispatcher

This block sits between a set of interrupt request lines and a bank of DMA channels. It decides, for every pending request, whether a DMA channel or the CPU services it. Each request line has a fixed vector code. Each channel holds a start vector. A channel claims every request whose code equals its start vector. Requests that no channel claims go to the CPU interrupt output together with their vector code.

Each claimed request becomes a request/acknowledge handshake on the winning channel. The acknowledge clears the source's pending flag and counts the channel's transfer counter down. When the count runs out, the channel raises a one-cycle end-of-transfer pulse and disarms itself by clearing its start vector. If several channels hold the same vector, the lowest-numbered armed one wins. Once it disarms, the next higher channel holding that vector takes over, so channels chain without software help. A write-only clear port lets software drop a pending flag by writing that source's vector code.

Top module: `dsv_dispatch`

## Requirements
- R1: After reset, all `dma_req_o`, `tc_irq_o` and `cpu_irq_o` outputs are low, every start vector is 0 and no flag is pending.
- R2: A pending request that no armed channel claims is shown on `cpu_irq_o`, with its code on `cpu_vec_o`. The lowest-numbered such source is shown first. `cpu_ack_i` clears the source currently shown. Source s has code 0x10 + 4*s.
- R3: Writes use `wr_addr_i[4:3]`: 0 writes the start vector of channel `wr_addr_i[2:0]` from `wr_data_i[7:0]`, 1 writes its transfer counter from `wr_data_i[15:0]`, 2 is the flag-clear port and 3 is ignored. A channel whose start vector equals a pending source's code raises `dma_req_o[c]` two clock edges after the request input. It holds the request until `dma_ack_i[c]`, and the source is not forwarded to the CPU.
- R4: An acknowledge clears the serviced source's pending flag, drops the channel's request on the same edge and decrements the channel's counter by one.
- R5: An acknowledge taken while the counter is 1 (or 0) raises `tc_irq_o[c]` for exactly one cycle and clears the start vector. Later requests from that source then go to the CPU.
- R6: When several armed channels hold the same start vector, only the lowest-numbered one requests.
- R7: When that lowest channel disarms, the next matching request goes to the next higher channel that holds the same vector.
- R8: Writing a source's code to the flag-clear port clears that source's pending flag. A code that belongs to no source changes no flag.
- R9: If a flag-clear write and a new request for the same source fall in the same cycle, the flag stays set.
- R10: A start vector of 0 disarms the channel, and it claims no source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 8 | Interrupt request pulses, one per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register kind [4:3] and channel [2:0] |
| wr_data_i | input | 16 | Write data |
| dma_req_o | output | 8 | Per-channel transfer request |
| dma_ack_i | input | 8 | Per-channel transfer acknowledge |
| tc_irq_o | output | 8 | Per-channel end-of-transfer pulse |
| cpu_irq_o | output | 1 | Forwarded interrupt valid |
| cpu_vec_o | output | 8 | Vector code of forwarded interrupt |
| cpu_ack_i | input | 1 | CPU accepted the forwarded interrupt |

## Verification
The assertions assume that `dma_ack_i[c]` is raised only while `dma_req_o[c]` is high. They also assume that software does not rewrite a busy channel's start vector to move its source to another channel mid-transfer. The bench meets both: it acknowledges only a channel it has just seen requesting, and it reprograms vectors only while every channel is idle. Random rounds draw start vectors from a small set of codes, including 0, so that duplicates and disarmed channels come up often. Each round raises one source and compares the requesting channel, or the CPU vector, with a bench priority function.

// File: rtl/dsv_pkg.sv
package dsv_pkg;
  typedef enum logic [1:0] {
    KIND_VEC = 2'd0,
    KIND_CNT = 2'd1,
    KIND_CLR = 2'd2,
    KIND_RSV = 2'd3
  } wr_kind_e;

  function automatic int src_code(input int base, input int step, input int idx);
    return base + step * idx;
  endfunction
endpackage

// File: rtl/dsv_chan.sv
module dsv_chan #(
  parameter int VEC_W = 8,
  parameter int CNT_W = 16,
  parameter int SRC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vec_we_i,
  input  logic [VEC_W-1:0] vec_wd_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wd_i,
  input  logic             cand_vld_i,
  input  logic [SRC_W-1:0] cand_src_i,
  input  logic             ack_i,
  output logic [VEC_W-1:0] vec_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             req_o,
  output logic [SRC_W-1:0] src_o,
  output logic             done_o,
  output logic             tc_o
);
  logic [VEC_W-1:0] vec_q;
  logic [CNT_W-1:0] cnt_q;
  logic             req_q, tc_q;
  logic [SRC_W-1:0] src_q;
  logic             fire, last;

  assign fire = req_q & ack_i;
  assign last = (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '0;
      cnt_q <= '0;
      req_q <= 1'b0;
      src_q <= '0;
      tc_q  <= 1'b0;
    end else begin
      tc_q <= fire & last;
      if (fire) begin
        req_q <= 1'b0;
      end else if (!req_q && cand_vld_i) begin
        req_q <= 1'b1;
        src_q <= cand_src_i;
      end
      // software rewrite wins over auto-disarm
      if (vec_we_i)          vec_q <= vec_wd_i;
      else if (fire && last) vec_q <= '0;
      if (cnt_we_i)                 cnt_q <= cnt_wd_i;
      else if (fire && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign vec_o  = vec_q;
  assign cnt_o  = cnt_q;
  assign req_o  = req_q;
  assign src_o  = src_q;
  assign done_o = fire;
  assign tc_o   = tc_q;
endmodule

// File: rtl/dsv_match.sv
module dsv_match #(
  parameter int N_CH     = 8,
  parameter int N_SRC    = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 16,
  parameter int VEC_STEP = 4,
  localparam int CH_W    = $clog2(N_CH),
  localparam int SRC_W   = $clog2(N_SRC)
) (
  input  logic [N_CH-1:0][VEC_W-1:0] vec_i,
  input  logic [N_SRC-1:0]           pend_i,
  output logic [N_SRC-1:0]           claimed_o,
  output logic [N_CH-1:0]            cand_vld_o,
  output logic [N_CH-1:0][SRC_W-1:0] cand_src_o
);
  import dsv_pkg::*;

  logic [N_SRC-1:0][CH_W-1:0] owner;

  // owner of each source: lowest armed channel with a matching vector
  always_comb begin
    claimed_o = '0;
    owner     = '0;
    for (int s = 0; s < N_SRC; s++) begin
      for (int c = N_CH - 1; c >= 0; c--) begin
        if (vec_i[c] != '0 && vec_i[c] == VEC_W'(src_code(VEC_BASE, VEC_STEP, s))) begin
          claimed_o[s] = 1'b1;
          owner[s]     = CH_W'(c);
        end
      end
    end
  end

  // per channel: lowest pending source it owns
  always_comb begin
    cand_vld_o = '0;
    cand_src_o = '0;
    for (int c = 0; c < N_CH; c++) begin
      for (int s = N_SRC - 1; s >= 0; s--) begin
        if (pend_i[s] && claimed_o[s] && owner[s] == CH_W'(c)) begin
          cand_vld_o[c] = 1'b1;
          cand_src_o[c] = SRC_W'(s);
        end
      end
    end
  end
endmodule

// File: rtl/dsv_pend.sv
module dsv_pend #(
  parameter int N_SRC    = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 16,
  parameter int VEC_STEP = 4,
  localparam int SRC_W   = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic [N_SRC-1:0] claimed_i,
  output logic [N_SRC-1:0] pend_o,
  output logic             fwd_vld_o,
  output logic [SRC_W-1:0] fwd_src_o,
  output logic [VEC_W-1:0] fwd_vec_o
);
  import dsv_pkg::*;

  logic [N_SRC-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;  // new request beats clear
  end

  always_comb begin
    fwd_vld_o = 1'b0;
    fwd_src_o = '0;
    fwd_vec_o = '0;
    for (int s = N_SRC - 1; s >= 0; s--) begin
      if (pend_q[s] && !claimed_i[s]) begin
        fwd_vld_o = 1'b1;
        fwd_src_o = SRC_W'(s);
        fwd_vec_o = VEC_W'(src_code(VEC_BASE, VEC_STEP, s));
      end
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dsv_dispatch.sv
module dsv_dispatch #(
  parameter int N_CH     = 8,
  parameter int N_SRC    = 8,
  parameter int VEC_W    = 8,
  parameter int CNT_W    = 16,
  parameter int VEC_BASE = 16,
  parameter int VEC_STEP = 4,
  localparam int CH_W    = $clog2(N_CH),
  localparam int SRC_W   = $clog2(N_SRC),
  localparam int ADDR_W  = CH_W + 2,
  localparam int DATA_W  = (CNT_W > VEC_W) ? CNT_W : VEC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [N_CH-1:0]   dma_req_o,
  input  logic [N_CH-1:0]   dma_ack_i,
  output logic [N_CH-1:0]   tc_irq_o,
  output logic              cpu_irq_o,
  output logic [VEC_W-1:0]  cpu_vec_o,
  input  logic              cpu_ack_i
);
  import dsv_pkg::*;

  wr_kind_e                   wr_kind;
  logic [CH_W-1:0]            wr_ch;
  logic                       clr_we;
  logic [N_CH-1:0]            vec_we, cnt_we, done, cand_vld;
  logic [N_CH-1:0][VEC_W-1:0] vec_all;
  logic [N_CH-1:0][CNT_W-1:0] cnt_all;
  logic [N_CH-1:0][SRC_W-1:0] src_all, cand_src;
  logic [N_SRC-1:0]           pend, claimed, clr;
  logic                       fwd_vld;
  logic [SRC_W-1:0]           fwd_src;

  assign wr_kind = wr_kind_e'(wr_addr_i[ADDR_W-1 -: 2]);
  assign wr_ch   = wr_addr_i[CH_W-1:0];
  assign clr_we  = wr_en_i && wr_kind == KIND_CLR;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign vec_we[c] = wr_en_i && wr_kind == KIND_VEC && wr_ch == CH_W'(c);
    assign cnt_we[c] = wr_en_i && wr_kind == KIND_CNT && wr_ch == CH_W'(c);

    dsv_chan #(.VEC_W(VEC_W), .CNT_W(CNT_W), .SRC_W(SRC_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .vec_we_i   (vec_we[c]),
      .vec_wd_i   (wr_data_i[VEC_W-1:0]),
      .cnt_we_i   (cnt_we[c]),
      .cnt_wd_i   (wr_data_i[CNT_W-1:0]),
      .cand_vld_i (cand_vld[c]),
      .cand_src_i (cand_src[c]),
      .ack_i      (dma_ack_i[c]),
      .vec_o      (vec_all[c]),
      .cnt_o      (cnt_all[c]),
      .req_o      (dma_req_o[c]),
      .src_o      (src_all[c]),
      .done_o     (done[c]),
      .tc_o       (tc_irq_o[c])
    );
  end

  dsv_match #(
    .N_CH(N_CH), .N_SRC(N_SRC), .VEC_W(VEC_W),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_match (
    .vec_i      (vec_all),
    .pend_i     (pend),
    .claimed_o  (claimed),
    .cand_vld_o (cand_vld),
    .cand_src_o (cand_src)
  );

  // pending-flag clears: flag-clear write, DMA acknowledge, CPU acknowledge
  always_comb begin
    clr = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (clr_we && wr_data_i[VEC_W-1:0] == VEC_W'(src_code(VEC_BASE, VEC_STEP, s)))
        clr[s] = 1'b1;
    end
    for (int c = 0; c < N_CH; c++) begin
      if (done[c]) clr[src_all[c]] = 1'b1;
    end
    if (cpu_ack_i && fwd_vld) clr[fwd_src] = 1'b1;
  end

  dsv_pend #(
    .N_SRC(N_SRC), .VEC_W(VEC_W),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (irq_i),
    .clr_i     (clr),
    .claimed_i (claimed),
    .pend_o    (pend),
    .fwd_vld_o (fwd_vld),
    .fwd_src_o (fwd_src),
    .fwd_vec_o (cpu_vec_o)
  );

  assign cpu_irq_o = fwd_vld;
endmodule

// File: rtl/dsv_dispatch_chk.sv
module dsv_dispatch_chk #(
  parameter int N_CH  = 8,
  parameter int VEC_W = 8,
  parameter int CNT_W = 16
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [N_CH-1:0]            dma_req_o,
  input logic [N_CH-1:0]            dma_ack_i,
  input logic [N_CH-1:0]            tc_irq_o,
  input logic                       cpu_irq_o,
  input logic [VEC_W-1:0]           cpu_vec_o,
  input logic [N_CH-1:0]            vec_we,
  input logic [N_CH-1:0]            cnt_we,
  input logic [N_CH-1:0][VEC_W-1:0] vec_all,
  input logic [N_CH-1:0][CNT_W-1:0] cnt_all
);
  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    a_r3_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dma_req_o[c] && !dma_ack_i[c] |=> dma_req_o[c]);

    a_r4_req_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dma_req_o[c] && dma_ack_i[c] |=> !dma_req_o[c]);

    a_r4_cnt_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dma_req_o[c] && dma_ack_i[c] && cnt_all[c] > CNT_W'(1) && !cnt_we[c]
      |=> cnt_all[c] == CNT_W'($past(cnt_all[c]) - CNT_W'(1)));

    a_r5_tc_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tc_irq_o[c] |=> !tc_irq_o[c]);

    a_r5_tc_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tc_irq_o[c] |-> $past(dma_req_o[c] && dma_ack_i[c]));

    a_r5_tc_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tc_irq_o[c] && !$past(vec_we[c]) |-> vec_all[c] == '0);

    a_r2_fwd_unclaimed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_irq_o |-> vec_all[c] != cpu_vec_o);
  end
endmodule

bind dsv_dispatch dsv_dispatch_chk #(
  .N_CH(N_CH), .VEC_W(VEC_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dma_req_o (dma_req_o),
  .dma_ack_i (dma_ack_i),
  .tc_irq_o  (tc_irq_o),
  .cpu_irq_o (cpu_irq_o),
  .cpu_vec_o (cpu_vec_o),
  .vec_we    (vec_we),
  .cnt_we    (cnt_we),
  .vec_all   (vec_all),
  .cnt_all   (cnt_all)
);

// File: tb/dsv_dispatch_tb.sv
module dsv_dispatch_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  irq_i = '0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [7:0]  dma_req_o;
  logic [7:0]  dma_ack_i = '0;
  logic [7:0]  tc_irq_o;
  logic        cpu_irq_o;
  logic [7:0]  cpu_vec_o;
  logic        cpu_ack_i = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] bvec [8];

  always #5 clk_i = ~clk_i;

  dsv_dispatch u_dut (.*);

  function automatic logic [7:0] code(input int s);
    return 8'(16 + 4 * s);
  endfunction

  function automatic int exp_owner(input int s);
    for (int c = 0; c < 8; c++)
      if (bvec[c] != 8'h00 && bvec[c] == code(s)) return c;
    return -1;
  endfunction

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] kind, input logic [2:0] ch, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = {kind, ch}; wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
    if (kind == 2'd0) bvec[ch] = d[7:0];
  endtask

  task automatic raise(input int s);
    irq_i[s] = 1'b1;
    tick();
    irq_i = '0;
    tick();
  endtask

  task automatic dack(input int c);
    dma_ack_i[c] = 1'b1;
    tick();
    dma_ack_i = '0;
  endtask

  task automatic cack();
    cpu_ack_i = 1'b1;
    tick();
    cpu_ack_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int c = 0; c < 8; c++) bvec[c] = 8'h00;
    tick(); tick();
    rst_ni = 1'b1;
    tick();

    // R1 reset state
    chk("R1 dma_req", 32'(dma_req_o), 0);
    chk("R1 tc", 32'(tc_irq_o), 0);
    chk("R1 cpu_irq", 32'(cpu_irq_o), 0);

    // R2 forwarding, lowest first
    irq_i[2] = 1'b1; irq_i[5] = 1'b1;
    tick(); irq_i = '0; tick();
    chk("R2 cpu_irq", 32'(cpu_irq_o), 1);
    chk("R2 first vec", 32'(cpu_vec_o), 32'(code(2)));
    cack();
    chk("R2 second vec", 32'(cpu_vec_o), 32'(code(5)));
    cack();
    chk("R2 drained", 32'(cpu_irq_o), 0);

    // R10 zero vector disarmed
    wr(2'd0, 3'd1, 16'h0000);
    raise(0);
    chk("R10 dma_req", 32'(dma_req_o), 0);
    chk("R10 fwd vec", 32'(cpu_vec_o), 32'(code(0)));
    cack();

    // R3 R4 R5 single channel, count 3
    wr(2'd0, 3'd3, 16'(code(1)));
    wr(2'd1, 3'd3, 16'd3);
    raise(1);
    chk("R3 req ch3", 32'(dma_req_o), 32'h08);
    chk("R3 not fwd", 32'(cpu_irq_o), 0);
    tick(); tick();
    chk("R3 req held", 32'(dma_req_o), 32'h08);
    dack(3);
    chk("R4 req drop", 32'(dma_req_o), 0);
    chk("R4 no tc at 2", 32'(tc_irq_o), 0);
    tick();
    chk("R4 flag cleared", 32'(dma_req_o), 0);
    raise(1); dack(3);
    chk("R4 no tc at 1", 32'(tc_irq_o), 0);
    raise(1); dack(3);
    chk("R5 tc pulse", 32'(tc_irq_o), 32'h08);
    tick();
    chk("R5 tc one cycle", 32'(tc_irq_o), 0);
    bvec[3] = 8'h00;
    raise(1);
    chk("R5 disarmed req", 32'(dma_req_o), 0);
    chk("R5 disarmed fwd", 32'(cpu_vec_o), 32'(code(1)));
    cack();

    // R6 R7 duplicate vectors and chaining
    wr(2'd0, 3'd2, 16'(code(4)));
    wr(2'd1, 3'd2, 16'd1);
    wr(2'd0, 3'd6, 16'(code(4)));
    wr(2'd1, 3'd6, 16'd2);
    raise(4);
    chk("R6 lowest wins", 32'(dma_req_o), 32'h04);
    dack(2);
    chk("R6 tc ch2", 32'(tc_irq_o), 32'h04);
    bvec[2] = 8'h00;
    raise(4);
    chk("R7 chain to ch6", 32'(dma_req_o), 32'h40);
    dack(6);
    raise(4);
    chk("R7 ch6 again", 32'(dma_req_o), 32'h40);
    dack(6);
    chk("R7 tc ch6", 32'(tc_irq_o), 32'h40);
    bvec[6] = 8'h00;
    tick();

    // R8 flag clear by vector
    raise(3);
    wr(2'd2, 3'd0, 16'h00FF);
    tick();
    chk("R8 foreign code no effect", 32'(cpu_vec_o), 32'(code(3)));
    wr(2'd2, 3'd0, 16'(code(3)));
    tick();
    chk("R8 cleared", 32'(cpu_irq_o), 0);

    // R9 new request beats same-cycle clear
    irq_i[7] = 1'b1;
    wr(2'd2, 3'd0, 16'(code(7)));
    irq_i = '0;
    tick();
    chk("R9 set wins", 32'(cpu_irq_o), 1);
    chk("R9 vec", 32'(cpu_vec_o), 32'(code(7)));
    cack();

    // random rounds
    for (int it = 0; it < 40; it++) begin
      for (int c = 0; c < 8; c++) begin
        int pick;
        pick = int'($urandom % 5);
        wr(2'd0, 3'(c), (pick == 0) ? 16'h0000 : 16'(code(pick - 1)));
        wr(2'd1, 3'(c), 16'hFFFF);
      end
      begin
        int s, own;
        s = int'($urandom % 4);
        own = exp_owner(s);
        raise(s);
        if (own >= 0) begin
          chk("R6 rand owner", 32'(dma_req_o), 32'(1 << own));
          chk("R3 rand not fwd", 32'(cpu_irq_o), 0);
          dack(own);
          chk("R4 rand drop", 32'(dma_req_o), 0);
          chk("R5 rand no tc", 32'(tc_irq_o), 0);
        end else begin
          chk("R10 rand fwd", 32'({cpu_irq_o, cpu_vec_o}), 32'({1'b1, code(s)}));
          chk("R10 rand no req", 32'(dma_req_o), 0);
          cack();
          chk("R2 rand cleared", 32'(cpu_irq_o), 0);
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule